// File: doc/BRIEF.md
# Serial Save-Memory Command Engine

This block models a small save memory that answers a byte-wide serial command protocol. The host presents one byte per strobe together with a hold flag that stands in for chip select. The first held byte after hold was idle is taken as an opcode. The bytes that follow it are interpreted under that opcode. They can collect a two-byte address, stream bytes out of or into an internal byte array, report a status byte, set or clear a write-enable latch, or answer an identity query. Every strobe produces a registered reply byte, and the host reads that byte back before it sends the next one.

A byte sent with hold low is still handled under the opcode that is in force, and it ends the transaction. The byte held after it is therefore a new opcode. Bit-level shifting, preload from outside and access delays are not modelled. The array holds `MEM_BYTES` bytes and is addressed by a 16-bit address. Addresses at or past the end of the array read back zero and ignore writes.

The controller is a state machine with the following states:
- `ST_OTHER`: unknown opcode, and the reset state.
- `ST_RD_ADDR` and `ST_RD_DATA`: read, collecting the address and then streaming data.
- `ST_WR_ADDR` and `ST_WR_DATA`: write, collecting the address and then storing data.
- `ST_STATUS`, `ST_WREN`, `ST_WRDI` and `ST_IDQ`: status, write enable, write disable and identity.

Any strobe that starts a command moves the machine to the state decoded from the opcode. After the last address byte, the machine moves from `ST_RD_ADDR` to `ST_RD_DATA`, or from `ST_WR_ADDR` to `ST_WR_DATA`. Every other strobe leaves the state unchanged.

Top module: `spi_save_engine`

## Requirements
- R1: After reset the reply byte is 0x00, the status byte reads 0x00, and the first held byte is treated as an opcode.
- R2: A held byte that arrives while no transaction is open becomes the opcode. On that strobe the reply becomes 0x00 and the address becomes 0.
- R3: A byte that arrives with hold low is processed under the current opcode and closes the transaction. The next held byte is decoded as a new opcode.
- R4: For opcode 0x03 (read), the two bytes after the opcode form the address, high byte first. The reply is 0x00 on both of them.
- R5: For opcode 0x03, each later byte returns the array byte at the current address and then advances the address by one. An address at or above `MEM_BYTES` returns 0x00.
- R6: Opcode 0x06 sets status bit 1 (the write-enable latch) on each following byte, and opcode 0x04 clears it. Both reply 0x00.
- R7: Opcode 0x05 replies with the status byte on every following byte. Bit 1 of that byte is the write-enable latch, and all other bits are 0.
- R8: Opcode 0x9F replies 0xFF on every following byte.
- R9: Under any other opcode, the following bytes leave the reply unchanged.
- R10: The reply register changes only on a strobe. It shows its new value in the cycle after the strobe edge and holds it while no strobe arrives.
- R11: For opcode 0x02 (write), the two bytes after the opcode form the address, high byte first. Each later byte is stored at the current address, which then advances. A byte is stored only while status bit 1 is set and only below `MEM_BYTES`. Every byte of the command replies 0x00.
- R12: A byte with hold low under opcode 0x02, in either the address or the data phase, clears status bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_valid | input | 1 | Strobe: a byte is present this cycle |
| byte_in | input | 8 | Incoming byte |
| hold_in | input | 1 | Hold flag sent with the byte (chip select) |
| byte_out | output | 8 | Registered reply byte |

## Verification
Every reply depends on one register stage. The result of a strobe sampled at one rising edge appears on `byte_out` from that edge on. The bench drives each byte on a falling edge and reads the reply on the next falling edge, exactly one cycle later. Effects on the array and on the latch are not visible directly. They are therefore checked through the next read or status command, each of which is again one cycle per byte. During idle gaps the bench samples the reply on several consecutive falling edges and requires it to stay constant.

// File: rtl/save_eng_pkg.sv
package save_eng_pkg;

    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_STAT  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_IDQ   = 8'h9F;

    localparam logic [7:0] ID_REPLY = 8'hFF;

    typedef enum logic [3:0] {
        ST_OTHER,
        ST_RD_ADDR,
        ST_RD_DATA,
        ST_WR_ADDR,
        ST_WR_DATA,
        ST_STATUS,
        ST_WREN,
        ST_WRDI,
        ST_IDQ
    } eng_state_e;

    function automatic eng_state_e decode_op(input logic [7:0] op);
        unique case (op)
            OP_WRITE: return ST_WR_ADDR;
            OP_READ:  return ST_RD_ADDR;
            OP_WRDI:  return ST_WRDI;
            OP_STAT:  return ST_STATUS;
            OP_WREN:  return ST_WREN;
            OP_IDQ:   return ST_IDQ;
            default:  return ST_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/save_eng_addr.sv
module save_eng_addr #(
    parameter int ADDR_BYTES = 2,
    parameter int MEM_BYTES  = 2048,
    localparam int ADDR_W    = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift,
    input  logic              inc,
    input  logic [7:0]        byte_in,
    output logic [ADDR_W-1:0] addr,
    output logic              in_range
);

    generate
        if (ADDR_BYTES > 1) begin : g_wide
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     addr <= '0;
                else if (clr)   addr <= '0;
                else if (shift) addr <= {addr[ADDR_W-9:0], byte_in};
                else if (inc)   addr <= addr + {{(ADDR_W-1){1'b0}}, 1'b1};
            end
        end else begin : g_narrow
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     addr <= '0;
                else if (clr)   addr <= '0;
                else if (shift) addr <= byte_in;
                else if (inc)   addr <= addr + {{(ADDR_W-1){1'b0}}, 1'b1};
            end
        end
    endgenerate

    assign in_range = ({{(32-ADDR_W){1'b0}}, addr} < MEM_BYTES);

endmodule

// File: rtl/save_eng_ram.sv
module save_eng_ram #(
    parameter int MEM_BYTES = 2048,
    localparam int IDX_W    = $clog2(MEM_BYTES)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);

    logic [7:0] cells [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (we) cells[idx] <= wdata;
    end

    assign rdata = cells[idx];

endmodule

// File: rtl/save_eng_ctrl.sv
module save_eng_ctrl
    import save_eng_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    localparam int POS_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    input  logic       hold_in,
    input  logic [7:0] rd_data,
    input  logic       in_range,
    output logic       addr_clr,
    output logic       addr_shift,
    output logic       addr_inc,
    output logic       mem_we,
    output logic [7:0] byte_out
);

    eng_state_e       state, state_n;
    logic             hold_q, hold_n;
    logic [POS_W-1:0] pos, pos_n;
    logic [7:0]       out_q, out_n;
    logic             wel_q, wel_n;
    logic             start;

    assign start    = byte_valid && hold_in && !hold_q;
    assign byte_out = out_q;

    always_comb begin
        state_n    = state;
        hold_n     = hold_q;
        pos_n      = pos;
        out_n      = out_q;
        wel_n      = wel_q;
        addr_clr   = 1'b0;
        addr_shift = 1'b0;
        addr_inc   = 1'b0;
        mem_we     = 1'b0;
        if (start) begin
            state_n  = decode_op(byte_in);
            hold_n   = 1'b1;
            pos_n    = '0;
            out_n    = 8'h00;
            addr_clr = 1'b1;
        end else if (byte_valid) begin
            hold_n = hold_in;
            unique case (state)
                ST_RD_ADDR: begin
                    addr_shift = 1'b1;
                    out_n      = 8'h00;
                    pos_n      = pos + {{(POS_W-1){1'b0}}, 1'b1};
                    if (pos == POS_W'(ADDR_BYTES - 1)) state_n = ST_RD_DATA;
                end
                ST_RD_DATA: begin
                    out_n    = in_range ? rd_data : 8'h00;
                    addr_inc = 1'b1;
                end
                ST_WR_ADDR: begin
                    addr_shift = 1'b1;
                    out_n      = 8'h00;
                    pos_n      = pos + {{(POS_W-1){1'b0}}, 1'b1};
                    if (pos == POS_W'(ADDR_BYTES - 1)) state_n = ST_WR_DATA;
                    if (!hold_in) wel_n = 1'b0;
                end
                ST_WR_DATA: begin
                    out_n    = 8'h00;
                    mem_we   = wel_q && in_range;
                    addr_inc = 1'b1;
                    if (!hold_in) wel_n = 1'b0;
                end
                ST_STATUS: out_n = {6'b0, wel_q, 1'b0};
                ST_WREN: begin
                    wel_n = 1'b1;
                    out_n = 8'h00;
                end
                ST_WRDI: begin
                    wel_n = 1'b0;
                    out_n = 8'h00;
                end
                ST_IDQ:   out_n = ID_REPLY;
                ST_OTHER: out_n = out_q;
                default:  out_n = out_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_OTHER;
            hold_q <= 1'b0;
            pos    <= '0;
        end else begin
            state  <= state_n;
            hold_q <= hold_n;
            pos    <= pos_n;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 8'h00;
            wel_q <= 1'b0;
        end else begin
            out_q <= out_n;
            wel_q <= wel_n;
        end
    end

    p_reply_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> $stable(byte_out));

    p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (byte_out == 8'h00));

    p_id_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !start && state == ST_IDQ) |=> (byte_out == 8'hFF));

    p_wren_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !start && state == ST_WREN) |=> wel_q);

    p_wrdi_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !start && state == ST_WRDI) |=> !wel_q);

    p_release_wel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !hold_in && (state == ST_WR_ADDR || state == ST_WR_DATA))
        |=> !wel_q);

    p_unknown_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !start && state == ST_OTHER) |=> $stable(byte_out));

endmodule

// File: rtl/spi_save_engine.sv
module spi_save_engine #(
    parameter int MEM_BYTES  = 2048,
    parameter int ADDR_BYTES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    input  logic       hold_in,
    output logic [7:0] byte_out
);

    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int IDX_W  = $clog2(MEM_BYTES);

    logic              addr_clr, addr_shift, addr_inc, mem_we, in_range;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        rd_data;

    save_eng_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .hold_in    (hold_in),
        .rd_data    (rd_data),
        .in_range   (in_range),
        .addr_clr   (addr_clr),
        .addr_shift (addr_shift),
        .addr_inc   (addr_inc),
        .mem_we     (mem_we),
        .byte_out   (byte_out)
    );

    save_eng_addr #(.ADDR_BYTES(ADDR_BYTES), .MEM_BYTES(MEM_BYTES)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (addr_clr),
        .shift    (addr_shift),
        .inc      (addr_inc),
        .byte_in  (byte_in),
        .addr     (addr),
        .in_range (in_range)
    );

    save_eng_ram #(.MEM_BYTES(MEM_BYTES)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .idx   (addr[IDX_W-1:0]),
        .wdata (byte_in),
        .rdata (rd_data)
    );

    p_write_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ({{(32-ADDR_W){1'b0}}, addr} < MEM_BYTES));

endmodule

// File: tb/tb_spi_save_engine.sv
module tb_spi_save_engine;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       hold_in = 1'b0;
    logic [7:0] byte_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [7:0] mdl [DEPTH];
    bit wel_m = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_save_engine #(.MEM_BYTES(DEPTH), .ADDR_BYTES(2)) dut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
        .byte_in(byte_in), .hold_in(hold_in), .byte_out(byte_out)
    );

    function automatic logic [7:0] exp_rd(input int a);
        return (a < DEPTH) ? mdl[a] : 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input bit h, output logic [7:0] o);
        byte_in    = b;
        hold_in    = h;
        byte_valid = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0;
        o = byte_out;
    endtask

    task automatic status_chk(input string tag);
        logic [7:0] o;
        send(8'h05, 1'b1, o);
        chk({tag, " status opcode"}, o, 8'h00);
        send(8'h00, 1'b1, o);
        chk({tag, " status R7"}, o, {6'b0, wel_m, 1'b0});
        send(8'h00, 1'b0, o);
        chk({tag, " status again R7"}, o, {6'b0, wel_m, 1'b0});
    endtask

    task automatic wren();
        logic [7:0] o;
        send(8'h06, 1'b1, o);
        send(8'h00, 1'b0, o);
        chk("R6 wren reply", o, 8'h00);
        wel_m = 1'b1;
    endtask

    task automatic write_seq(input int a, input int n);
        logic [7:0] o;
        send(8'h02, 1'b1, o);
        send(a[15:8], 1'b1, o);
        chk("R11 write addr hi", o, 8'h00);
        send(a[7:0], 1'b1, o);
        chk("R11 write addr lo", o, 8'h00);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            send(d, (i != n - 1), o);
            chk("R11 write data reply", o, 8'h00);
            if (wel_m && (a + i) < DEPTH) mdl[a + i] = d;
        end
        wel_m = 1'b0;
    endtask

    task automatic read_seq(input int a, input int n);
        logic [7:0] o;
        send(8'h03, 1'b1, o);
        chk("R2 read opcode reply", o, 8'h00);
        send(a[15:8], 1'b1, o);
        chk("R4 addr hi reply", o, 8'h00);
        send(a[7:0], 1'b1, o);
        chk("R4 addr lo reply", o, 8'h00);
        for (int i = 0; i < n; i++) begin
            send(8'h00, (i != n - 1), o);
            chk("R5 read data", o, exp_rd(a + i));
        end
    endtask

    initial begin
        logic [7:0] o;
        logic [7:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 reset reply", byte_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reply after reset", byte_out, 8'h00);
        status_chk("R1");

        // identity, hold-low continuation, new opcode
        send(8'h9F, 1'b1, o);
        chk("R2 id opcode reply", o, 8'h00);
        send(8'h12, 1'b0, o);
        chk("R8 id reply", o, 8'hFF);
        send(8'h55, 1'b0, o);
        chk("R3 hold-low byte under same opcode", o, 8'hFF);
        send(8'h05, 1'b1, o);
        chk("R3 next held byte is opcode", o, 8'h00);
        send(8'h00, 1'b0, o);
        chk("R3 status under new opcode", o, 8'h00);

        // unknown opcode
        send(8'h77, 1'b1, o);
        send(8'hAB, 1'b1, o);
        chk("R9 unknown keeps reply", o, 8'h00);
        send(8'hCD, 1'b0, o);
        chk("R9 unknown keeps reply on release", o, 8'h00);

        // latch control
        wren();
        status_chk("R6 after wren");
        send(8'h04, 1'b1, o);
        send(8'h00, 1'b0, o);
        chk("R6 wrdi reply", o, 8'h00);
        wel_m = 1'b0;
        status_chk("R6 after wrdi");

        // fill the array
        wren();
        write_seq(0, DEPTH);
        status_chk("R12 after write release");

        read_seq(0, 8);
        read_seq(DEPTH - 4, 8);
        read_seq(16'hFFF0, 3);

        // idle stability
        read_seq(5, 1);
        held = byte_out;
        repeat (4) begin
            @(negedge clk);
            chk("R10 reply holds while idle", byte_out, held);
        end

        // write without latch is ignored
        write_seq(16, 4);
        read_seq(16, 4);

        // write straddling the array end
        wren();
        write_seq(DEPTH - 2, 4);
        read_seq(DEPTH - 3, 5);

        // release during address phase clears latch
        wren();
        send(8'h02, 1'b1, o);
        send(8'h00, 1'b0, o);
        wel_m = 1'b0;
        status_chk("R12 release in address phase");

        for (int it = 0; it < 40; it++) begin
            int op;
            int a;
            int n;
            op = int'($urandom % 4);
            a  = int'($urandom % (DEPTH + 16));
            n  = 1 + int'($urandom % 6);
            unique case (op)
                0: begin wren(); write_seq(a, n); end
                1: write_seq(a, n);
                2: read_seq(a, n);
                default: status_chk("R7 random");
            endcase
            repeat (int'($urandom % 3)) @(negedge clk);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule